// File: doc/BRIEF.md
# SD Auto-Command Response Error Checker

This block sits beside the command-line engine of an SD host controller. When the controller sends a stop command (CMD12) or a block-count command (CMD23) by itself, without software asking for it, the block watches the serial command line for the card's answer. It first counts SD clock cycles after the end bit of the issued command and reports a timeout if no start bit appears. If a start bit does appear, the block shifts in the 48-bit response, checks its framing, its CRC7 and its command index, and can also check the card-status error field of an R1 response. The results go into a sticky status register whose bits hide one another in a fixed order, and a one-cycle interrupt pulse is raised.

The host controller also reports cases where it could not send the stop command at all because of an earlier error. These set a separate status bit that hides every other result. A companion bit marks a waiting command without data that was held back by a stop-command error. An error from a CMD23 forces both of these bits to zero. Software clears the status bits by writing a one to each bit it wants cleared.

The controller runs four states. ST_IDLE goes to ST_WAIT on `start_i`. ST_WAIT goes to ST_RECV when the line reads 0 (start bit), or back to ST_IDLE on timeout. ST_RECV goes to ST_EVAL after the last response bit. ST_EVAL always goes back to ST_IDLE.

Top module: `sd_autocmd_errchk`

## Requirements
- R1: After `start_i` is sampled at edge E0, the line is sampled at edges E1 to E64. If it reads 1 at all 64 of these edges, status bit 1 (timeout) is set at E64. A start bit at E64 is still accepted.
- R2: Status bit 3 (framing) is set when the final response bit is 0 or when the second response bit (the transmission bit) is 1.
- R3: Status bit 2 (CRC) is set when the 7 bits that come before the final bit differ from the CRC7 over the first 40 bits. The CRC7 uses polynomial x^7+x^3+1, starts from 0 and takes the most significant bit first.
- R4: Status bit 4 (index) is set when response bits 2 to 7 (the 6-bit index, sent most significant bit first) differ from `cmd_idx_i` as captured with `start_i`.
- R5: While bit 1 is set, or when a timeout happens in the same event, bits 2, 3 and 4 are not newly set.
- R6: Status bit 5 (card status) is set only when `resp_chk_en_i` was high at `start_i` and any of argument bits 31 to 19 is 1. It is not set when any of bits 0 to 4 is set or is being set by the same event.
- R7: `stop_fail_i` while the checker is idle and `xfer_started_i` is high sets status bit 0. Without `xfer_started_i` it has no effect. While bit 0 is set, bits 1 to 5 are not newly set by events from a stop command.
- R8: Bit 7 is set when a stop-command event (`auto_kind_i`=0) reports any error while `pend_nodata_i` is high. Any error from a CMD23 (`auto_kind_i`=1) leaves bits 0 and 7 at 0.
- R9: After reset all status bits are 0. Bits 15 to 8 and bit 6 are always 0.
- R10: Status bits stay set until a `clr_we_i` write with a 1 in that bit of `clr_mask_i`. `err_irq_o` pulses for one cycle only when at least one bit goes from 0 to 1.
- R11: Response results appear one clock after the edge that samples the final response bit. A timeout appears at the sampling edge itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | SD clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Pulse: end bit of the automatic command has just been sent |
| cmd_idx_i | input | 6 | Index of the issued command |
| auto_kind_i | input | 1 | 0 = stop command, 1 = block-count command |
| resp_chk_en_i | input | 1 | Enable for the card-status check |
| cmd_line_i | input | 1 | Serial command-line bit, idle high |
| stop_fail_i | input | 1 | Pulse: stop command could not be sent |
| xfer_started_i | input | 1 | A multi-block transfer is in progress |
| pend_nodata_i | input | 1 | A command without data is waiting |
| clr_we_i | input | 1 | Write strobe for clearing status bits |
| clr_mask_i | input | 8 | Write-one-to-clear mask |
| status_o | output | 16 | Sticky error status |
| err_irq_o | output | 1 | One-cycle pulse when a status bit is newly set |

## Verification
A response's verdict becomes visible two falling edges after the bench drives the final bit: the first falling edge follows the sampling edge and the second follows the evaluation edge. The bench checks that the status is still unchanged at the first of these and correct at the second. A timeout shows one falling edge after the 64th idle-high sample, and the bench checks the 63rd sample point as well, so that an early flag is caught. A stop-failure pulse and a clear write both show at the falling edge after the rising edge that samples them. The interrupt is compared at the same point as the status, because it is a one-cycle pulse that is only present there.

// File: rtl/sd_aerr_pkg.sv
package sd_aerr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_RECV,
        ST_EVAL
    } aerr_state_e;

    localparam int unsigned B_NEXEC = 0;
    localparam int unsigned B_TO    = 1;
    localparam int unsigned B_CRC   = 2;
    localparam int unsigned B_END   = 3;
    localparam int unsigned B_IDX   = 4;
    localparam int unsigned B_RESP  = 5;
    localparam int unsigned B_BLK   = 7;
    localparam int unsigned LIVE_W  = 8;

    typedef struct packed {
        logic valid;
        logic is_bcnt;
        logic pend;
        logic nexec;
        logic to;
        logic crc;
        logic endb;
        logic idx;
        logic r1;
    } aerr_ev_t;

endpackage

// File: rtl/sd_crc7.sv
module sd_crc7 #(
    parameter int unsigned    W    = 7,
    parameter logic [W-1:0]   POLY = 7'h09
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         en_i,
    input  logic         bit_i,
    output logic [W-1:0] crc_o
);
    logic [W-1:0] crc_q, base, nxt;
    logic         fb;

    always_comb begin
        base = clr_i ? '0 : crc_q;
        fb   = bit_i ^ base[W-1];
        nxt  = {base[W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    crc_q <= '0;
        else if (en_i) crc_q <= nxt;
    end

    assign crc_o = crc_q;
endmodule

// File: rtl/sd_resp_shift.sv
module sd_resp_shift #(
    parameter int unsigned N     = 47,
    parameter int unsigned IDX_W = 6,
    parameter int unsigned CRC_W = 7,
    parameter int unsigned R1_HI = 31,
    parameter int unsigned R1_LO = 19
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   en_i,
    input  logic                   bit_i,
    output logic                   trans_o,
    output logic [IDX_W-1:0]       idx_o,
    output logic [R1_HI-R1_LO:0]   r1_o,
    output logic [CRC_W-1:0]       crc_o,
    output logic                   end_o
);
    localparam int unsigned ARG_LO = CRC_W + 1;

    logic [N-1:0] q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q <= '0;
        else if (en_i) q <= {q[N-2:0], bit_i};
    end

    assign trans_o = q[N-1];
    assign idx_o   = q[N-2 -: IDX_W];
    assign r1_o    = q[ARG_LO+R1_HI : ARG_LO+R1_LO];
    assign crc_o   = q[CRC_W:1];
    assign end_o   = q[0];
endmodule

// File: rtl/sd_aerr_status.sv
module sd_aerr_status
    import sd_aerr_pkg::*;
#(
    parameter int unsigned SW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  aerr_ev_t          ev_i,
    input  logic              clr_we_i,
    input  logic [LIVE_W-1:0] clr_mask_i,
    output logic [SW-1:0]     status_o,
    output logic              irq_o
);
    logic [LIVE_W-1:0] stat_q, keep, set_v, nxt;
    logic              irq_q, blk_all, to_any, lo_busy, any_err;

    always_comb begin
        keep    = stat_q & ~(clr_we_i ? clr_mask_i : '0);
        blk_all = ~ev_i.is_bcnt & (stat_q[B_NEXEC] | ev_i.nexec);
        to_any  = stat_q[B_TO] | ev_i.to;
        any_err = ev_i.nexec | ev_i.to | ev_i.crc | ev_i.endb | ev_i.idx | ev_i.r1;
        set_v   = '0;
        lo_busy = 1'b0;
        if (ev_i.valid) begin
            set_v[B_NEXEC] = ev_i.nexec & ~ev_i.is_bcnt;
            set_v[B_TO]    = ev_i.to   & ~blk_all;
            set_v[B_CRC]   = ev_i.crc  & ~blk_all & ~to_any;
            set_v[B_END]   = ev_i.endb & ~blk_all & ~to_any;
            set_v[B_IDX]   = ev_i.idx  & ~blk_all & ~to_any;
            lo_busy        = |(stat_q[4:0] | set_v[4:0]);
            set_v[B_RESP]  = ev_i.r1 & ~lo_busy & ~blk_all;
            set_v[B_BLK]   = ev_i.pend & any_err & ~ev_i.is_bcnt;
        end
        nxt = keep | set_v;
        if (ev_i.valid && ev_i.is_bcnt && any_err) begin
            nxt[B_NEXEC] = 1'b0;
            nxt[B_BLK]   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            stat_q <= nxt;
            irq_q  <= |(set_v & ~stat_q);
        end
    end

    assign status_o = {{(SW-LIVE_W){1'b0}}, stat_q};
    assign irq_o    = irq_q;
endmodule

// File: rtl/sd_autocmd_errchk.sv
module sd_autocmd_errchk
    import sd_aerr_pkg::*;
#(
    parameter int unsigned TO_CYC = 64,
    parameter int unsigned RESP_W = 48,
    parameter int unsigned IDX_W  = 6,
    parameter int unsigned CRC_W  = 7,
    parameter int unsigned STAT_W = 16,
    parameter int unsigned R1_HI  = 31,
    parameter int unsigned R1_LO  = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [IDX_W-1:0]  cmd_idx_i,
    input  logic              auto_kind_i,
    input  logic              resp_chk_en_i,
    input  logic              cmd_line_i,
    input  logic              stop_fail_i,
    input  logic              xfer_started_i,
    input  logic              pend_nodata_i,
    input  logic              clr_we_i,
    input  logic [7:0]        clr_mask_i,
    output logic [STAT_W-1:0] status_o,
    output logic              err_irq_o
);
    localparam int unsigned CNT_W    = $clog2(TO_CYC);
    localparam int unsigned BIT_W    = $clog2(RESP_W);
    localparam int unsigned CRC_SPAN = RESP_W - CRC_W - 1;
    localparam int unsigned R1_N     = R1_HI - R1_LO + 1;

    aerr_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [BIT_W-1:0] bit_q;
    logic [IDX_W-1:0] idx_q;
    logic             kind_q, en_q;

    logic             start_seen, to_hit, last_bit;
    logic             sh_en, crc_en, crc_clr;
    logic             f_trans, f_end;
    logic [IDX_W-1:0] f_idx;
    logic [R1_N-1:0]  f_r1;
    logic [CRC_W-1:0] f_crc, calc_crc;
    aerr_ev_t         ev;

    assign start_seen = (state_q == ST_WAIT) && !cmd_line_i;
    assign to_hit     = (state_q == ST_WAIT) && cmd_line_i && (cnt_q == CNT_W'(TO_CYC-1));
    assign last_bit   = (bit_q == BIT_W'(RESP_W-1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_WAIT;
            ST_WAIT: begin
                if (start_seen)  state_d = ST_RECV;
                else if (to_hit) state_d = ST_IDLE;
            end
            ST_RECV: if (last_bit) state_d = ST_EVAL;
            ST_EVAL: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // counters and captured command context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            bit_q  <= '0;
            idx_q  <= '0;
            kind_q <= 1'b0;
            en_q   <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && start_i) begin
                cnt_q  <= '0;
                idx_q  <= cmd_idx_i;
                kind_q <= auto_kind_i;
                en_q   <= resp_chk_en_i;
            end else if (state_q == ST_WAIT && cmd_line_i) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (start_seen)                      bit_q <= BIT_W'(1);
            else if (state_q == ST_RECV && !last_bit) bit_q <= bit_q + 1'b1;
        end
    end

    assign sh_en   = (state_q == ST_RECV);
    assign crc_clr = start_seen;
    assign crc_en  = start_seen || (state_q == ST_RECV && bit_q < BIT_W'(CRC_SPAN));

    sd_crc7 #(.W(CRC_W)) u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (crc_clr),
        .en_i  (crc_en),
        .bit_i (cmd_line_i),
        .crc_o (calc_crc)
    );

    sd_resp_shift #(
        .N     (RESP_W-1),
        .IDX_W (IDX_W),
        .CRC_W (CRC_W),
        .R1_HI (R1_HI),
        .R1_LO (R1_LO)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (sh_en),
        .bit_i   (cmd_line_i),
        .trans_o (f_trans),
        .idx_o   (f_idx),
        .r1_o    (f_r1),
        .crc_o   (f_crc),
        .end_o   (f_end)
    );

    // output (event) process
    always_comb begin
        ev         = '0;
        ev.is_bcnt = kind_q;
        ev.pend    = pend_nodata_i;
        unique case (state_q)
            ST_IDLE: begin
                if (stop_fail_i && xfer_started_i && !start_i) begin
                    ev.valid   = 1'b1;
                    ev.nexec   = 1'b1;
                    ev.is_bcnt = 1'b0;
                end
            end
            ST_WAIT: begin
                if (to_hit) begin
                    ev.valid = 1'b1;
                    ev.to    = 1'b1;
                end
            end
            ST_EVAL: begin
                ev.valid = 1'b1;
                ev.endb  = !f_end || f_trans;
                ev.crc   = (f_crc != calc_crc);
                ev.idx   = (f_idx != idx_q);
                ev.r1    = en_q && (|f_r1);
            end
            default: ;
        endcase
    end

    sd_aerr_status #(.SW(STAT_W)) u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_i       (ev),
        .clr_we_i   (clr_we_i),
        .clr_mask_i (clr_mask_i),
        .status_o   (status_o),
        .irq_o      (err_irq_o)
    );
endmodule

// File: rtl/sd_aerr_chk.sv
module sd_aerr_chk #(
    parameter int unsigned SW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [SW-1:0] status_i,
    input logic          irq_i
);
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (status_i[SW-1:8] == '0) && !status_i[6]);  // R9

    AST_IRQ_ON_NEW: assert property (@(posedge clk) disable iff (!rst_n)
        irq_i |-> ((status_i & ~$past(status_i)) != '0));  // R10

    AST_TO_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(status_i[1]) && status_i[1]) |-> ((status_i[4:2] & ~$past(status_i[4:2])) == '0));  // R5

    AST_NEXEC_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(status_i[0]) && status_i[0]) |-> ((status_i[5:1] & ~$past(status_i[5:1])) == '0));  // R7

    AST_RESP_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (status_i[5] && !$past(status_i[5])) |-> (($past(status_i[4:0]) == '0) && (status_i[4:0] == '0)));  // R6
endmodule

bind sd_autocmd_errchk sd_aerr_chk #(.SW(STAT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .status_i (status_o),
    .irq_i    (err_irq_o)
);

// File: tb/sim_sd_autocmd_errchk.sv
module sim_sd_autocmd_errchk;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [5:0]  cmd_idx_i = '0;
    logic        auto_kind_i = 1'b0;
    logic        resp_chk_en_i = 1'b0;
    logic        cmd_line_i = 1'b1;
    logic        stop_fail_i = 1'b0;
    logic        xfer_started_i = 1'b0;
    logic        pend_nodata_i = 1'b0;
    logic        clr_we_i = 1'b0;
    logic [7:0]  clr_mask_i = '0;
    logic [15:0] status_o;
    logic        err_irq_o;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    sd_autocmd_errchk u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmd_idx_i(cmd_idx_i),
        .auto_kind_i(auto_kind_i), .resp_chk_en_i(resp_chk_en_i), .cmd_line_i(cmd_line_i),
        .stop_fail_i(stop_fail_i), .xfer_started_i(xfer_started_i), .pend_nodata_i(pend_nodata_i),
        .clr_we_i(clr_we_i), .clr_mask_i(clr_mask_i), .status_o(status_o), .err_irq_o(err_irq_o)
    );

    typedef struct packed {
        logic [6:0]  dly;
        logic [5:0]  iidx;
        logic [5:0]  ridx;
        logic [31:0] arg;
        logic        crc_bad;
        logic        endb;
        logic        kind;
        logic        en;
        logic        pend;
        logic [7:0]  exp;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{7'd2,  6'd12, 6'd12, 32'h0000_0900, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00}, // R2 R3 R4 clean
        '{7'd5,  6'd12, 6'd13, 32'h0000_0900, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h10}, // R4
        '{7'd1,  6'd12, 6'd12, 32'h0000_0900, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'h84}, // R3 R8
        '{7'd0,  6'd23, 6'd23, 32'h0000_0000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h08}, // R2 R8
        '{7'd3,  6'd12, 6'd12, 32'h8000_0000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h20}, // R6
        '{7'd3,  6'd12, 6'd12, 32'h8000_0000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00}, // R6 disabled
        '{7'd3,  6'd12, 6'd12, 32'h0008_0000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h20}, // R6 bit19
        '{7'd2,  6'd12, 6'd12, 32'h0004_0000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00}, // R6 bit18
        '{7'd3,  6'd12, 6'd11, 32'h8000_0000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h10}, // R6 suppressed
        '{7'd64, 6'd12, 6'd12, 32'h0000_0000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'h82}, // R1 R8
        '{7'd63, 6'd12, 6'd12, 32'h0000_0000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00}, // R1 edge
        '{7'd64, 6'd23, 6'd23, 32'h0000_0000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'h02}, // R1 R8
        '{7'd4,  6'd12, 6'd5,  32'h0000_0000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h1C}  // R2 R3 R4
    };

    function automatic logic [6:0] crc7_of(input logic [39:0] d);
        logic [6:0] c;
        c = '0;
        for (int i = 39; i >= 0; i--) begin
            logic f;
            f = d[i] ^ c[6];
            c = {c[5:0], 1'b0};
            if (f) c = c ^ 7'h09;
        end
        return c;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clear(input logic [7:0] m);
        @(negedge clk); clr_we_i = 1'b1; clr_mask_i = m;
        @(negedge clk); clr_we_i = 1'b0; clr_mask_i = '0;
    endtask

    task automatic send(input int dly, input logic [5:0] iidx, input logic [5:0] ridx,
                        input logic [31:0] arg, input logic crc_bad, input logic endb,
                        input logic trans, input logic kind, input logic en, input logic pend,
                        input logic [7:0] pre, input logic [7:0] exp, input string tag);
        logic [47:0] fr;
        logic [39:0] head;
        head = {1'b0, trans, ridx, arg};
        fr = {head, crc7_of(head) ^ {6'd0, crc_bad}, endb};
        @(negedge clk);
        start_i = 1'b1; cmd_idx_i = iidx; auto_kind_i = kind;
        resp_chk_en_i = en; pend_nodata_i = pend; cmd_line_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (dly >= 64) begin
            repeat (63) @(negedge clk);
            check({tag, " R11 early"}, {16'd0, status_o}, {24'd0, pre});
            @(negedge clk);
        end else begin
            repeat (dly) @(negedge clk);
            for (int b = 47; b >= 0; b--) begin
                cmd_line_i = fr[b];
                @(negedge clk);
            end
            cmd_line_i = 1'b1;
            check({tag, " R11 early"}, {16'd0, status_o}, {24'd0, pre});
            @(negedge clk);
        end
        check({tag, " status"}, {16'd0, status_o}, {24'd0, exp});
        check({tag, " R10 irq"}, {31'd0, err_irq_o}, {31'd0, |(exp & ~pre)});
    endtask

    task automatic stop_fail(input logic xs, input logic pend, input logic [7:0] pre,
                             input logic [7:0] exp, input string tag);
        @(negedge clk); stop_fail_i = 1'b1; xfer_started_i = xs; pend_nodata_i = pend;
        @(negedge clk); stop_fail_i = 1'b0; xfer_started_i = 1'b0;
        check({tag, " status"}, {16'd0, status_o}, {24'd0, exp});
        check({tag, " R10 irq"}, {31'd0, err_irq_o}, {31'd0, |(exp & ~pre)});
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R9 reset status", {16'd0, status_o}, 32'd0);
        check("R9 reset irq", {31'd0, err_irq_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            clear(8'hFF);
            send(int'(VEC[v].dly), VEC[v].iidx, VEC[v].ridx, VEC[v].arg, VEC[v].crc_bad,
                 VEC[v].endb, 1'b0, VEC[v].kind, VEC[v].en, VEC[v].pend, 8'h00, VEC[v].exp,
                 $sformatf("vec%0d", v));
        end

        // R2 transmission bit set
        clear(8'hFF);
        send(2, 6'd12, 6'd12, 32'h0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 8'h08, "R2 trans");

        // R7 R8 stop failure, then masking of a later stop-command error
        clear(8'hFF);
        stop_fail(1'b1, 1'b1, 8'h00, 8'h81, "R7 R8 nexec");
        send(1, 6'd12, 6'd12, 32'h0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h81, 8'h81, "R7 mask");
        // R10 W1C of bit 0 only
        clear(8'h01);
        check("R10 w1c", {16'd0, status_o}, 32'h80);
        // R7 no transfer started: ignored
        stop_fail(1'b0, 1'b0, 8'h80, 8'h80, "R7 no xfer");

        // R8 CMD23 error clears bits 0 and 7
        clear(8'hFF);
        stop_fail(1'b1, 1'b1, 8'h00, 8'h81, "R8 pre");
        send(1, 6'd23, 6'd23, 32'h0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'h81, 8'h04, "R8 cmd23");

        // R5 sticky timeout hides later CRC error
        clear(8'hFF);
        send(64, 6'd12, 6'd12, 32'h0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h02, "R5 to");
        send(2, 6'd12, 6'd12, 32'h0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h02, 8'h02, "R5 mask");

        // R10 repeated error: sticky, no second pulse
        clear(8'hFF);
        send(1, 6'd12, 6'd9, 32'h0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h10, "R10 first");
        send(1, 6'd12, 6'd9, 32'h0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h10, 8'h10, "R10 again");

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule